// File: doc/BRIEF.md
# Serial Controller Status Word

This block keeps the status byte of a serial communication controller and presents it to the host processor. The receiver reports each loaded character with a strobe, together with qualifiers for a bad parity bit and a missing stop bit. The transmitter supplies two levels: its data buffer is empty, and it has gone idle. A sync/break detector supplies a third level. Two active-low modem inputs are synchronised inside the block. Two command-register bits arrive as inputs: transmit enable, and a clear for the sticky errors.

The host reads the byte with a read strobe while the control/data select is high. During such a read the presented byte is frozen. Flag updates still collect in an internal live copy and appear once the read ends. A read with the select low is a data read, and it consumes the pending received character. A separate ready-to-transmit pin combines the empty-buffer condition with the clear-to-send modem input and the transmit enable. The ready bit inside the byte shows only the empty buffer.

Top module: `sio_status_reg`

## Requirements
- R1: The byte layout, most significant bit first, is: data-set-ready, sync/break, framing error, overrun, parity error, transmitter idle, receive ready, transmit buffer empty.
- R2: After reset the presented byte is 8'h05, and the transmit-ready pin is 0 while transmit enable is 0.
- R3: While cpu_rd and cpu_cd are both 1, status_q does not change. Events in that window are applied afterwards and appear on status_q one clock after the read ends.
- R4: A character load with rx_parity_bad set sets the parity flag. The flag stays set until an error-clear command, and reception continues.
- R5: A character load while receive ready is set sets the overrun flag, unless a data read (cpu_rd=1, cpu_cd=0) happens in the same cycle.
- R6: A character load with rx_stop_bad sets the framing flag only when async_mode is 1. It never sets in synchronous mode.
- R7: A command write (cmd_wr=1) with cmd_err_rst=1 clears the parity, overrun and framing flags. An error set in that same cycle wins and leaves its flag at 1.
- R8: Receive ready sets on a character load and clears on a data read. A load in the same cycle as a data read leaves it set.
- R9: The data-set-ready bit is the inverse of dsr_n after a two-stage synchroniser. It reaches status_q four clocks after a change.
- R10: Bit 0 equals tx_buf_empty, delayed by two clocks. txrdy_pin is 1 only when the registered buffer-empty level is 1, the synchronised cts_n is 0 and cmd_tx_en is 1.
- R11: With no status read pending, any status change appears on status_q within 28 clocks of its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_char_load | input | 1 | Receiver loaded a character (one-cycle strobe) |
| rx_parity_bad | input | 1 | Loaded character had a parity error |
| rx_stop_bad | input | 1 | Loaded character lacked a valid stop bit |
| async_mode | input | 1 | 1 = asynchronous framing, 0 = synchronous |
| tx_buf_empty | input | 1 | Transmit data buffer empty (level) |
| tx_idle | input | 1 | Transmitter has nothing left to shift (level) |
| sync_brk_det | input | 1 | Sync or break detected (level) |
| dsr_n | input | 1 | Data-set-ready modem input, active low, asynchronous |
| cts_n | input | 1 | Clear-to-send modem input, active low, asynchronous |
| cmd_wr | input | 1 | Command write strobe |
| cmd_err_rst | input | 1 | Error-clear bit of the command word |
| cmd_tx_en | input | 1 | Transmit enable bit of the command register |
| cpu_rd | input | 1 | Host read strobe |
| cpu_cd | input | 1 | Control/data select: 1 selects status, 0 selects data |
| status_q | output | 8 | Presented status byte |
| txrdy_pin | output | 1 | Gated transmit-ready output |

## Verification
The hardest case to reach is a collision inside one cycle. A character load can meet a data read, an error-clear command, or both, while receive ready is already set. Each ordering gives a different flag outcome. The bench sweeps every combination of preloaded ready, parity fault, stop fault, framing mode, same-cycle data read and same-cycle clear. It compares every cycle with a cycle model written from the requirements. A second hard case is an event that lands during a long status read. The bench holds the read over several cycles while faults and a modem change arrive, then confirms the deferred values appear once the read drops.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;

  typedef struct packed {
    logic dsr;
    logic synbrk;
    logic fe;
    logic oe;
    logic pe;
    logic txempty;
    logic rxrdy;
    logic txrdy;
  } sio_stat_t;

  localparam int STAT_W = $bits(sio_stat_t);
  localparam logic [STAT_W-1:0] STAT_RST = 8'h05;

  function automatic logic txrdy_gate(input logic buf_empty, input logic cts_low_n,
                                      input logic tx_en);
    return buf_empty & ~cts_low_n & tx_en;
  endfunction

  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
  import sio_status_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic char_load,
  input  logic parity_bad,
  input  logic stop_bad,
  input  logic async_mode,
  input  logic data_rd,
  input  logic err_clr,
  output logic pe_q,
  output logic oe_q,
  output logic fe_q,
  output logic rxrdy_q
);
  logic pe_set, oe_set, fe_set;

  assign pe_set = char_load & parity_bad;
  assign fe_set = char_load & stop_bad & async_mode;
  assign oe_set = char_load & rxrdy_q & ~data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
      fe_q    <= 1'b0;
      rxrdy_q <= 1'b0;
    end else begin
      pe_q    <= sticky_next(pe_q, pe_set, err_clr);
      oe_q    <= sticky_next(oe_q, oe_set, err_clr);
      fe_q    <= sticky_next(fe_q, fe_set, err_clr);
      rxrdy_q <= sticky_next(rxrdy_q, char_load, data_rd);
    end
  end

  // R4
  a_r4_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pe_q && !err_clr |=> pe_q);
  // R5
  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    char_load && rxrdy_q && !data_rd |=> oe_q);
  // R6
  a_r6_no_fe_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !async_mode && !fe_q |=> !fe_q);
  // R7
  a_r7_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !char_load |=> !pe_q && !oe_q && !fe_q);
  // R8
  a_r8_rxrdy_load: assert property (@(posedge clk) disable iff (!rst_n)
    char_load |=> rxrdy_q);
endmodule

// File: rtl/sio_stat_hold.sv
module sio_stat_hold
  import sio_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [STAT_W-1:0] live,
  output logic [STAT_W-1:0] shown
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shown <= STAT_RST;
    else if (!hold) shown <= live;
  end

  // R3
  a_r3_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(shown));
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
  import sio_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_char_load,
  input  logic       rx_parity_bad,
  input  logic       rx_stop_bad,
  input  logic       async_mode,
  input  logic       tx_buf_empty,
  input  logic       tx_idle,
  input  logic       sync_brk_det,
  input  logic       dsr_n,
  input  logic       cts_n,
  input  logic       cmd_wr,
  input  logic       cmd_err_rst,
  input  logic       cmd_tx_en,
  input  logic       cpu_rd,
  input  logic       cpu_cd,
  output logic [7:0] status_q,
  output logic       txrdy_pin
);
  localparam int MODEM_W = 2;

  logic stat_rd, data_rd, err_clr;
  logic [MODEM_W-1:0] modem_s;
  logic dsr_s, cts_s;
  logic dsr_l, syn_l, txe_l, tbe_l;
  logic pe_q, oe_q, fe_q, rxrdy_q;
  sio_stat_t live;

  assign stat_rd = cpu_rd & cpu_cd;
  assign data_rd = cpu_rd & ~cpu_cd;
  assign err_clr = cmd_wr & cmd_err_rst;

  sio_sync #(.STAGES(SYNC_STAGES), .W(MODEM_W), .RST_VAL(2'b11)) u_modem_sync (
    .clk(clk), .rst_n(rst_n), .d({dsr_n, cts_n}), .q(modem_s));
  assign dsr_s = modem_s[1];
  assign cts_s = modem_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsr_l <= 1'b0;
      syn_l <= 1'b0;
      txe_l <= 1'b1;
      tbe_l <= 1'b1;
    end else begin
      dsr_l <= ~dsr_s;
      syn_l <= sync_brk_det;
      txe_l <= tx_idle;
      tbe_l <= tx_buf_empty;
    end
  end

  sio_rx_flags u_rx_flags (
    .clk(clk), .rst_n(rst_n), .char_load(rx_char_load), .parity_bad(rx_parity_bad),
    .stop_bad(rx_stop_bad), .async_mode(async_mode), .data_rd(data_rd),
    .err_clr(err_clr), .pe_q(pe_q), .oe_q(oe_q), .fe_q(fe_q), .rxrdy_q(rxrdy_q));

  always_comb begin
    live.dsr     = dsr_l;
    live.synbrk  = syn_l;
    live.fe      = fe_q;
    live.oe      = oe_q;
    live.pe      = pe_q;
    live.txempty = txe_l;
    live.rxrdy   = rxrdy_q;
    live.txrdy   = tbe_l;
  end

  sio_stat_hold u_hold (
    .clk(clk), .rst_n(rst_n), .hold(stat_rd), .live(live), .shown(status_q));

  assign txrdy_pin = txrdy_gate(tbe_l, cts_s, cmd_tx_en);

  // R10
  a_r10_pin_off_when_cts_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cts_n) && cts_n |=> !txrdy_pin);
  // R10
  a_r10_pin_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_tx_en |-> !txrdy_pin);
endmodule

// File: tb/sim_sio_status_reg.sv
`timescale 1ns/1ps
module sim_sio_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 0, pbad = 0, sbad = 0, amode = 1, tbe = 1, idle = 1, syn = 0;
  logic dsr_n = 1, cts_n = 1, cwr = 0, crst = 0, txen = 0, rd = 0, cd = 0;
  logic [7:0] status_q;
  logic txrdy_pin;

  int checks = 0, errors = 0;

  logic m_pe = 0, m_oe = 0, m_fe = 0, m_rx = 0, m_dsr = 0, m_syn = 0, m_txe = 1, m_tbe = 1;
  logic dp1 = 1, dp2 = 1, cp1 = 1, cp2 = 1;
  logic [7:0] m_sh = 8'h05;

  always #4 clk = ~clk;

  sio_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .rx_char_load(load), .rx_parity_bad(pbad),
    .rx_stop_bad(sbad), .async_mode(amode), .tx_buf_empty(tbe), .tx_idle(idle),
    .sync_brk_det(syn), .dsr_n(dsr_n), .cts_n(cts_n), .cmd_wr(cwr),
    .cmd_err_rst(crst), .cmd_tx_en(txen), .cpu_rd(rd), .cpu_cd(cd),
    .status_q(status_q), .txrdy_pin(txrdy_pin));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic drd, clr, hold;
    @(posedge clk);
    drd = rd & ~cd;
    clr = cwr & crst;
    hold = rd & cd;
    if (!hold) m_sh = {m_dsr, m_syn, m_fe, m_oe, m_pe, m_txe, m_rx, m_tbe};
    m_oe  = (load & m_rx & ~drd) | (m_oe & ~clr);
    m_pe  = (load & pbad) | (m_pe & ~clr);
    m_fe  = (load & sbad & amode) | (m_fe & ~clr);
    m_rx  = load | (m_rx & ~drd);
    m_dsr = ~dp2;
    m_syn = syn; m_txe = idle; m_tbe = tbe;
    dp2 = dp1; dp1 = dsr_n; cp2 = cp1; cp1 = cts_n;
    @(negedge clk);
    chk(tag, status_q, m_sh);
    chk({tag, " pin"}, {7'd0, txrdy_pin}, {7'd0, m_tbe & ~cp2 & txen});
    load = 0; pbad = 0; sbad = 0; cwr = 0; crst = 0; rd = 0;
  endtask

  task automatic clean();
    cwr = 1; crst = 1; rd = 1; cd = 0;
    step("R7 R8 clean");
    step("R7 R8 clean");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] cap;
    int n;
    repeat (3) @(negedge clk);
    chk("R2 reset byte", status_q, 8'h05);
    chk("R2 reset pin", {7'd0, txrdy_pin}, 8'h00);
    rst_n = 1;
    step("R2");
    step("R2");

    // R4 R5 R6 R7 R8: sweep of same-cycle collisions
    for (int i = 0; i < 64; i++) begin
      clean();
      if (i[5]) begin load = 1; step("R8 preload"); end
      load = 1; pbad = i[0]; sbad = i[1]; amode = i[2];
      if (i[3]) begin rd = 1; cd = 0; end
      if (i[4]) begin cwr = 1; crst = 1; end
      step("R4 R5 R6 R7 R8 event");
      step("R4 R5 R6 R7 R8 after");
      step("R4 R5 R6 R7 R8 settle");
    end
    amode = 1;

    // R1: parity only -> bit3 plus idle, ready, empty
    clean();
    load = 1; pbad = 1;
    step("R1"); step("R1");
    chk("R1 layout pe", status_q, 8'h0F);
    clean();
    load = 1; sbad = 1; step("R1"); step("R1");
    chk("R1 layout fe", status_q, 8'h27);
    load = 1; step("R1"); step("R1");
    chk("R1 layout oe", status_q, 8'h37);
    syn = 1; step("R1"); step("R1");
    chk("R1 layout syn", status_q, 8'h77);
    syn = 0;
    clean();

    // R3: freeze during a held status read
    step("R3");
    cap = status_q;
    for (int k = 0; k < 6; k++) begin
      rd = 1; cd = 1;
      if (k == 1) begin load = 1; pbad = 1; end
      if (k == 2) dsr_n = 0;
      if (k == 3) syn = 1;
      step("R3 frozen");
      chk("R3 held value", status_q, cap);
    end
    step("R3 release");
    chk("R3 deferred", status_q, 8'hCF);
    dsr_n = 1; syn = 0;
    repeat (5) step("R9");
    clean();

    // R9 R11: modem latency
    dsr_n = 0;
    n = 0;
    for (int k = 0; k < 28; k++) begin
      step("R9");
      n++;
      if (status_q[7]) break;
    end
    chk("R9 dsr latency", 8'(n), 8'd4);
    chk("R11 within bound", {7'd0, status_q[7]}, 8'h01);
    dsr_n = 1;
    repeat (5) step("R9");

    // R11: pulse event latency without a read
    load = 1; pbad = 1; step("R11"); step("R11");
    chk("R11 pe visible", {7'd0, status_q[3]}, 8'h01);
    clean();

    // R10: gating sweep
    for (int i = 0; i < 8; i++) begin
      tbe = i[0]; cts_n = i[1]; txen = i[2];
      repeat (4) step("R10");
      chk("R10 pin", {7'd0, txrdy_pin}, {7'd0, i[0] & ~i[1] & i[2]});
      chk("R10 bit0", {7'd0, status_q[0]}, {7'd0, i[0]});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule